// File: doc/BRIEF.md
# GPIO Interrupt Detection Bank

A bank of `NPINS` general-purpose inputs. Each pin has its own interrupt detection cell and the whole bank shares one combined interrupt line. Every pin first passes through a two-flop synchronizer. The synchronized sample then feeds two detectors:

- an edge detector, which compares the current sample with the sample from the previous cycle;
- a level detector.

A per-pin kind bit picks which detector may set that pin's sticky event bit. Once set, the event bit stays set until software clears it by writing a one to it. A clear only succeeds in a cycle in which the chosen condition is no longer being detected.

A per-pin block bit stops a latched event from reaching the interrupt line. It does not stop detection. An event that latches while its pin is blocked shows up on the line as soon as the block is removed.

Software reaches the bank through a plain single-cycle register port (address, write enable, write data, combinational read data). The port has no back-pressure: every access completes in the cycle it is presented. Pins are plain level inputs and are never stalled.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads as follows: kind reads 0 (all pins level), sense reads all ones, both-edges reads 0, block reads all ones, events read 0, and `irq_o` is 0.
- R2: The register addresses are 0 kind (1 = edge, 0 = level), 1 sense, 2 both-edges, 3 block (1 = blocked), 4 events (read, write-one-to-clear) and 5 synchronized pin level (read-only). Writes to 0..3 read back on the next cycle. Addresses 6 and 7 read 0.
- R3: In level mode, a sense bit of 1 makes a high level the condition and 0 makes a low level the condition. The event bit is set in every cycle the condition holds. A pin change reaches the event bit on the third rising clock edge.
- R4: In edge mode with both-edges clear, a sense bit of 1 detects rising edges and 0 detects falling edges. The opposite edge sets nothing.
- R5: In edge mode with both-edges set, both edges set the event bit regardless of sense.
- R6: A write of 1 to an event bit clears it only if the condition is not detected in that cycle. For an active level the clear has no effect. For an edge, a clear at any later cycle succeeds.
- R7: When a detection and a write-one clear land on the same pin in the same cycle, the event bit stays 1.
- R8: `irq_o` is the OR over all pins of event AND NOT block. Detection continues while a pin is blocked, and a latched event drives `irq_o` in the first cycle after the unblocking write.
- R9: The pin-level register shows each pin two clock edges after it changes. Writes to address 5, 6 or 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw pin levels |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write enable for the current cycle |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The cell assertions assume `clr_i` and the configuration bits are stable across each clock edge. They also assume the synchronized sample is the only source of the condition.

The bench meets these assumptions by changing inputs only 1 ns after a rising edge. It produces pin toggles at random, and the synchronizer absorbs any timing relation between those toggles and the clock.

Random writes to the configuration and event registers are interleaved with pin activity. This makes clears land in the same cycle as fresh detections, and mode switches land while events are pending.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_KIND  = 3'd0,
    REG_SENSE = 3'd1,
    REG_BOTH  = 3'd2,
    REG_BLOCK = 3'd3,
    REG_EVENT = 3'd4,
    REG_LEVEL = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic is_edge_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic clr_i,
  output logic event_o
);
  logic prev_q;
  logic event_q;
  logic rise;
  logic fall;
  logic cond;

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    if (is_edge_i) begin
      if (both_i)       cond = rise | fall;
      else if (sense_i) cond = rise;
      else              cond = fall;
    end else begin
      cond = sense_i ? smp_i : ~smp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      prev_q  <= smp_i;
      event_q <= cond | (event_q & ~clr_i);
    end
  end

  assign event_o = event_q;

  AST_SET_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
    cond |=> event_q); // R3
  AST_DETECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && clr_i) |=> event_q); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cond) |=> !event_q); // R6
  AST_HOLD_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (event_q && !clr_i) |=> event_q); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!event_q && !cond) |=> !event_q); // R4
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o
);
  localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

  logic [NPINS-1:0] kind_q, sense_q, both_q, block_q;
  logic [NPINS-1:0] level_s;
  logic [NPINS-1:0] events;
  logic [NPINS-1:0] clr_vec;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (level_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      sense_q <= ALL_ONES;
      both_q  <= '0;
      block_q <= ALL_ONES;
    end else if (we_i) begin
      case (addr_i)
        REG_KIND:  kind_q  <= wdata_i;
        REG_SENSE: sense_q <= wdata_i;
        REG_BOTH:  both_q  <= wdata_i;
        REG_BLOCK: block_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_vec = (we_i && addr_i == REG_EVENT) ? wdata_i : '0;

  for (genvar p = 0; p < NPINS; p++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_i     (level_s[p]),
      .is_edge_i (kind_q[p]),
      .sense_i   (sense_q[p]),
      .both_i    (both_q[p]),
      .clr_i     (clr_vec[p]),
      .event_o   (events[p])
    );
  end

  always_comb begin
    case (addr_i)
      REG_KIND:  rdata_o = kind_q;
      REG_SENSE: rdata_o = sense_q;
      REG_BOTH:  rdata_o = both_q;
      REG_BLOCK: rdata_o = block_q;
      REG_EVENT: rdata_o = events;
      REG_LEVEL: rdata_o = level_s;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = |(events & ~block_q);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (events != '0)); // R8
  AST_IRQ_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (block_q != ALL_ONES)); // R8
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic [2:0] addr_i = '0;
  logic we_i = 1'b0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_ev = '0;
  logic [N-1:0] m_kind = '0, m_sense = '1, m_both = '0, m_block = '1;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [N-1:0] cond_of(logic [N-1:0] s, logic [N-1:0] pv,
      logic [N-1:0] kd, logic [N-1:0] se, logic [N-1:0] bo);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (kd[i]) r[i] = bo[i] ? (s[i] ^ pv[i]) : (se[i] ? (s[i] & ~pv[i]) : (~s[i] & pv[i]));
      else       r[i] = se[i] ? s[i] : ~s[i];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [N-1:0] c, clr, nev;
    c   = cond_of(m_s2, m_prev, m_kind, m_sense, m_both);
    clr = (we_i && addr_i == 3'd4) ? wdata_i : '0;
    nev = c | (m_ev & ~clr);
    @(posedge clk);
    m_ev = nev; m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    if (we_i) case (addr_i)
      3'd0: m_kind = wdata_i;
      3'd1: m_sense = wdata_i;
      3'd2: m_both = wdata_i;
      3'd3: m_block = wdata_i;
      default: ;
    endcase
    #1;
    chk("R8 irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(m_ev & ~m_block)});
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    tick();
    we_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [N-1:0] exp);
    addr_i = a; we_i = 1'b0; #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #22 rst_n = 1'b1;
    #1;
    // R1 reset state
    rd("R1 kind", 3'd0, '0);
    rd("R1 sense", 3'd1, '1);
    rd("R1 both", 3'd2, '0);
    rd("R1 block", 3'd3, '1);
    rd("R1 events", 3'd4, '0);
    chk("R1 irq", {31'd0, irq_o}, '0);
    tick();
    // R2 readback, R8 unblock pin 0
    wr(3'd3, 32'hFFFF_FFFE);
    rd("R2 block readback", 3'd3, 32'hFFFF_FFFE);
    rd("R2 unused addr", 3'd6, '0);
    // R3 level high, three-edge latency
    pin_i[0] = 1'b1;
    ticks(2);
    rd("R3 not yet", 3'd4, '0);
    tick();
    rd("R3 level high sets", 3'd4, 32'h1);
    // R6 clear ignored while level active
    wr(3'd4, 32'h1);
    rd("R6 clear ignored", 3'd4, 32'h1);
    pin_i[0] = 1'b0;
    ticks(3);
    wr(3'd4, 32'h1);
    rd("R6 clear after release", 3'd4, '0);
    // R3 low level
    wr(3'd1, 32'hFFFF_FFFE);
    tick();
    rd("R3 level low sets", 3'd4, 32'h1);
    // R4 rising edge
    wr(3'd1, '1);
    wr(3'd0, 32'h1);
    wr(3'd4, 32'h1);
    rd("R4 no edge yet", 3'd4, '0);
    pin_i[0] = 1'b1;
    ticks(3);
    rd("R4 rising sets", 3'd4, 32'h1);
    ticks(4);
    wr(3'd4, 32'h1);
    rd("R6 late edge clear", 3'd4, '0);
    pin_i[0] = 1'b0;
    ticks(4);
    rd("R4 falling ignored when rising", 3'd4, '0);
    // R4 falling edge
    wr(3'd1, 32'hFFFF_FFFE);
    pin_i[0] = 1'b1; ticks(4);
    rd("R4 rising ignored when falling", 3'd4, '0);
    pin_i[0] = 1'b0; ticks(3);
    rd("R4 falling sets", 3'd4, 32'h1);
    wr(3'd4, 32'h1);
    // R5 both edges
    wr(3'd2, 32'h1);
    pin_i[0] = 1'b1; ticks(3);
    rd("R5 rising with both", 3'd4, 32'h1);
    // R7 clear lands in the detection cycle
    pin_i[0] = 1'b0; ticks(2);
    wr(3'd4, 32'h1);
    rd("R7 detection wins", 3'd4, 32'h1);
    wr(3'd4, 32'h1);
    rd("R5 cleared", 3'd4, '0);
    // R8 blocked detection then unblock
    wr(3'd3, '1);
    pin_i[0] = 1'b1; ticks(3);
    rd("R8 latched while blocked", 3'd4, 32'h1);
    chk("R8 irq low while blocked", {31'd0, irq_o}, '0);
    wr(3'd3, 32'hFFFF_FFFE);
    chk("R8 irq on unblock", {31'd0, irq_o}, 32'h1);
    // R9 raw level and ignored writes
    wr(3'd3, '1);
    pin_i = 32'hA5A5_0F0F;
    tick();
    rd("R9 one edge", 3'd5, 32'h0000_0001);
    tick();
    rd("R9 two edges", 3'd5, 32'hA5A5_0F0F);
    wr(3'd5, 32'h1234_5678);
    wr(3'd6, '1);
    wr(3'd7, '1);
    rd("R9 raw unchanged", 3'd5, 32'hA5A5_0F0F);
    rd("R9 kind unchanged", 3'd0, 32'h1);
    rd("R9 block unchanged", 3'd3, '1);
    rd("R9 events vs model", 3'd4, m_ev);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 15);
      pin_i = pin_i ^ ($urandom() & $urandom() & $urandom());
      if (r == 0)      wr(3'($urandom_range(0, 3)), $urandom());
      else if (r < 3)  wr(3'd4, $urandom());
      else             tick();
      if ((k % 7) == 0) rd("R3-model events", 3'd4, m_ev);
      if ((k % 53) == 0) rd("R9 model level", 3'd5, m_s2);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule